// File: doc/BRIEF.md
# HDLC Receive Frame Length Counter

This block sits behind an HDLC receiver on one channel. The receiver has already removed flags, undone bit stuffing and checked the CRC. It hands over one strobe per payload byte, and one end-of-frame strobe carrying a status byte. The block counts the payload bytes of the current frame into a 12-bit length. The length saturates at 4095, and an overflow flag records any frame that runs past that value. The block also tracks how many bytes wait in a 32-entry receive FIFO. The storage itself lives elsewhere; only the fill level is kept here.

The host reads the FIFO in blocks of 32 bytes. Each time a 32-byte block has built up, the block raises a one-cycle chunk-ready event. When a frame ends, it raises a one-cycle message-end event. At that point the fill level also counts the trailing status byte, and the frame length, overflow flag and status byte stay on the outputs for the host to read.

After a message end, the block ignores all traffic until the host acknowledges with a read strobe. The counter clears only when the first byte of the next frame arrives. This keeps the previous frame's length readable until new data actually flows.

Top module: `hdlc_rx_len_ctr`

## Requirements
- R1: After reset, `frame_len` is 0, `len_ovf` is 0, `fifo_fill` is 0, and `msg_end` and `chunk_rdy` are low.
- R2: Each accepted byte raises `frame_len` by one, visible in the cycle after the strobe. The first byte after reset or after a host acknowledge loads `frame_len` with 1. Until that byte arrives, the previous length stays on the output.
- R3: A byte accepted while `frame_len` is 4095 sets `len_ovf` and leaves `frame_len` at 4095, so the length never wraps. `len_ovf` stays set until the first byte of the next frame clears it.
- R4: `fifo_fill` gives the number of frame bytes now in the FIFO, which is the frame's byte count modulo 32. After a frame end it is one higher, for the status byte. While `len_ovf` is clear, the count part equals the low five bits of `frame_len`.
- R5: `chunk_rdy` pulses for exactly one cycle, in the cycle after each accepted byte that brings the FIFO to 32 bytes (byte 32, 64, ... of a frame). The fill part then restarts from 0.
- R6: An accepted end-of-frame strobe gives a `msg_end` pulse of exactly one cycle, in the next cycle. In that same cycle `frame_stat` shows the status byte given with the strobe.
- R7: When `byte_vld` and `eof_vld` are high in the same cycle, the byte counts as the frame's last payload byte before the frame ends.
- R8: From a message end until `host_rd`, the block ignores `byte_vld` and `eof_vld`. `frame_len`, `len_ovf`, `fifo_fill` and `frame_stat` do not change, and no event is raised. `host_rd` has no effect at any other time.
- R9: An `eof_vld` with no frame in progress (no byte since the last acknowledge or reset, and no `byte_vld` in the same cycle) is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_vld | input | 1 | One payload byte has arrived this cycle |
| eof_vld | input | 1 | Frame ends this cycle |
| eof_stat | input | 8 | Status byte that goes with `eof_vld` |
| host_rd | input | 1 | Host has read the counts and acknowledges the message end |
| frame_len | output | 12 | Saturating byte count of the current or last frame |
| len_ovf | output | 1 | Frame exceeded 4095 bytes |
| fifo_fill | output | 6 | Bytes held in the receive FIFO, including the status byte after a frame end |
| chunk_rdy | output | 1 | One-cycle event: a 32-byte block is ready in the FIFO |
| msg_end | output | 1 | One-cycle event: a frame has ended and its last part is in the FIFO |
| frame_stat | output | 8 | Status byte of the last completed frame |

## Verification
Every result is registered once. `frame_len`, `len_ovf`, `fifo_fill`, `frame_stat`, `chunk_rdy` and `msg_end` all take their new values at the first rising edge after the strobe. The bench drives each strobe at a falling edge and removes it at the next falling edge, so exactly one rising edge falls between the two. It then samples the outputs right after that second falling edge, which is where each result is due. The event outputs are sampled again one cycle later to confirm they last a single cycle. Ignored stimulus is checked by reading the held outputs after the strobe and before any later byte.

// File: rtl/hdlc_rlc_pkg.sv
package hdlc_rlc_pkg;

    // Default widths of the counter datapath
    localparam int LEN_W   = 12;  // frame length bits, saturates at 2**LEN_W-1
    localparam int CHUNK_W = 5;   // FIFO chunk of 2**CHUNK_W bytes
    localparam int STAT_W  = 8;   // status byte width

    // Frame reception state
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for the first byte of a frame
        ST_RECV = 2'd1,   // frame in progress
        ST_DONE = 2'd2    // message end raised, waiting for host acknowledge
    } rlc_state_e;

    // Per-cycle control decisions from the sequencer to the counters
    typedef struct packed {
        logic start;   // first byte of a new frame: clear and load
        logic accept;  // a byte is taken into the frame
        logic last;    // the frame ends this cycle
    } rlc_ctl_s;

    // Saturating increment: returns the value plus one unless already at all ones
    function automatic logic [LEN_W-1:0] sat_inc(input logic [LEN_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/rlc_seq.sv
module rlc_seq
    import hdlc_rlc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_vld,
    input  logic       eof_vld,
    input  logic       host_rd,
    output rlc_ctl_s   ctl,
    output rlc_state_e state,
    output logic       msg_end
);

    rlc_state_e state_q, state_d;
    logic       msg_end_q;

    always_comb begin
        ctl     = '0;
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (byte_vld) begin
                    ctl.start  = 1'b1;
                    ctl.accept = 1'b1;
                    ctl.last   = eof_vld;
                    state_d    = eof_vld ? ST_DONE : ST_RECV;
                end
            end
            ST_RECV: begin
                ctl.accept = byte_vld;
                ctl.last   = eof_vld;
                if (eof_vld) state_d = ST_DONE;
            end
            ST_DONE: begin
                if (host_rd) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            msg_end_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            msg_end_q <= ctl.last;
        end
    end

    assign state   = state_q;
    assign msg_end = msg_end_q;

endmodule

// File: rtl/rlc_len_ctr.sv
module rlc_len_ctr
    import hdlc_rlc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  rlc_ctl_s         ctl,
    output logic [LEN_W-1:0] len,
    output logic             ovf
);

    logic [LEN_W-1:0] len_q;
    logic             ovf_q;
    logic             at_max;

    assign at_max = &len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
            ovf_q <= 1'b0;
        end else if (ctl.start) begin
            len_q <= LEN_W'(1);
            ovf_q <= 1'b0;
        end else if (ctl.accept) begin
            len_q <= sat_inc(len_q);
            if (at_max) ovf_q <= 1'b1;
        end
    end

    assign len = len_q;
    assign ovf = ovf_q;

endmodule

// File: rtl/rlc_fill_trk.sv
module rlc_fill_trk
    import hdlc_rlc_pkg::*;
#(
    parameter int CW = CHUNK_W
) (
    input  logic        clk,
    input  logic        rst,
    input  rlc_ctl_s    ctl,
    output logic [CW:0] fill,
    output logic        chunk,
    output logic        eom
);

    logic [CW-1:0] resid_q;
    logic          chunk_q;
    logic          eom_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            resid_q <= '0;
            chunk_q <= 1'b0;
            eom_q   <= 1'b0;
        end else begin
            chunk_q <= ctl.accept && !ctl.start && (&resid_q);
            if (ctl.start)       resid_q <= CW'(1);
            else if (ctl.accept) resid_q <= resid_q + 1'b1;
            if (ctl.last)        eom_q   <= 1'b1;
            else if (ctl.start)  eom_q   <= 1'b0;
        end
    end

    assign fill  = {1'b0, resid_q} + {{CW{1'b0}}, eom_q};
    assign chunk = chunk_q;
    assign eom   = eom_q;

endmodule

// File: rtl/hdlc_rx_len_ctr.sv
module hdlc_rx_len_ctr
    import hdlc_rlc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic              eof_vld,
    input  logic [STAT_W-1:0] eof_stat,
    input  logic              host_rd,
    output logic [LEN_W-1:0]  frame_len,
    output logic              len_ovf,
    output logic [CHUNK_W:0]  fifo_fill,
    output logic              chunk_rdy,
    output logic              msg_end,
    output logic [STAT_W-1:0] frame_stat
);

    rlc_ctl_s          ctl;
    rlc_state_e        state;
    logic              eom;
    logic [STAT_W-1:0] stat_q;

    rlc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .byte_vld (byte_vld),
        .eof_vld  (eof_vld),
        .host_rd  (host_rd),
        .ctl      (ctl),
        .state    (state),
        .msg_end  (msg_end)
    );

    rlc_len_ctr u_len (
        .clk (clk),
        .rst (rst),
        .ctl (ctl),
        .len (frame_len),
        .ovf (len_ovf)
    );

    rlc_fill_trk #(.CW(CHUNK_W)) u_fill (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .fill  (fifo_fill),
        .chunk (chunk_rdy),
        .eom   (eom)
    );

    always_ff @(posedge clk) begin
        if (rst)           stat_q <= '0;
        else if (ctl.last) stat_q <= eof_stat;
    end

    assign frame_stat = stat_q;

endmodule

// File: rtl/hdlc_rx_len_ctr_chk.sv
module hdlc_rx_len_ctr_chk
    import hdlc_rlc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [LEN_W-1:0]  frame_len,
    input logic              len_ovf,
    input logic [CHUNK_W:0]  fifo_fill,
    input logic              chunk_rdy,
    input logic              msg_end,
    input logic [STAT_W-1:0] frame_stat,
    input rlc_state_e        state,
    input logic              eom
);

    AST_OVF_SATURATED: assert property (@(posedge clk) disable iff (rst)
        len_ovf |-> (&frame_len)); // R3

    AST_FILL_TRACKS_LEN: assert property (@(posedge clk) disable iff (rst)
        (!len_ovf && !eom) |-> (fifo_fill == {1'b0, frame_len[CHUNK_W-1:0]})); // R4

    AST_FILL_WITH_STATUS: assert property (@(posedge clk) disable iff (rst)
        (!len_ovf && eom) |-> (fifo_fill == {1'b0, frame_len[CHUNK_W-1:0]} + 1'b1)); // R4

    AST_CHUNK_PULSE: assert property (@(posedge clk) disable iff (rst)
        chunk_rdy |=> !chunk_rdy); // R5

    AST_CHUNK_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (chunk_rdy && !msg_end) |-> (fifo_fill == '0)); // R5

    AST_MSG_END_PULSE: assert property (@(posedge clk) disable iff (rst)
        msg_end |=> !msg_end); // R6

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) |=> ($stable(frame_len) && $stable(fifo_fill)
                                && $stable(frame_stat) && $stable(len_ovf)
                                && !msg_end && !chunk_rdy)); // R8

endmodule

bind hdlc_rx_len_ctr hdlc_rx_len_ctr_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_len  (frame_len),
    .len_ovf    (len_ovf),
    .fifo_fill  (fifo_fill),
    .chunk_rdy  (chunk_rdy),
    .msg_end    (msg_end),
    .frame_stat (frame_stat),
    .state      (state),
    .eom        (eom)
);

// File: tb/hdlc_rx_len_ctr_tb_top.sv
`timescale 1ns/1ps
module hdlc_rx_len_ctr_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_vld = 1'b0;
    logic        eof_vld = 1'b0;
    logic [7:0]  eof_stat = '0;
    logic        host_rd = 1'b0;
    logic [11:0] frame_len;
    logic        len_ovf;
    logic [5:0]  fifo_fill;
    logic        chunk_rdy;
    logic        msg_end;
    logic [7:0]  frame_stat;

    int checks = 0;
    int errors = 0;
    int chunk_seen;

    always #5 clk = ~clk;

    hdlc_rx_len_ctr dut_i (
        .clk        (clk),
        .rst        (rst),
        .byte_vld   (byte_vld),
        .eof_vld    (eof_vld),
        .eof_stat   (eof_stat),
        .host_rd    (host_rd),
        .frame_len  (frame_len),
        .len_ovf    (len_ovf),
        .fifo_fill  (fifo_fill),
        .chunk_rdy  (chunk_rdy),
        .msg_end    (msg_end),
        .frame_stat (frame_stat)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Called at a falling edge; drives for one cycle, returns at the next falling edge
    task automatic drive(input logic b, input logic e, input logic [7:0] s, input logic rd);
        byte_vld = b; eof_vld = e; eof_stat = s; host_rd = rd;
        @(negedge clk);
        byte_vld = 1'b0; eof_vld = 1'b0; host_rd = 1'b0;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
    endtask

    task automatic push_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            drive(1'b1, 1'b0, 8'h00, 1'b0);
            if (chunk_rdy) chunk_seen++;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "frame_len", frame_len, 0);
        chk("R1", "len_ovf", len_ovf, 0);
        chk("R1", "fifo_fill", fifo_fill, 0);
        chk("R1", "msg_end", msg_end, 0);
        chk("R1", "chunk_rdy", chunk_rdy, 0);
    endtask

    task automatic t_short_frame();
        drive(1'b1, 1'b0, 8'h00, 1'b0);
        chk("R2", "first byte len", frame_len, 1);
        push_bytes(4);
        chk("R2", "len after 5", frame_len, 5);
        chk("R4", "fill after 5", fifo_fill, 5);
        drive(1'b0, 1'b1, 8'hA5, 1'b0);
        chk("R6", "msg_end pulse", msg_end, 1);
        chk("R6", "status byte", frame_stat, 8'hA5);
        chk("R6", "fill incl status", fifo_fill, 6);
        chk("R6", "len at end", frame_len, 5);
        idle_cycle();
        chk("R6", "msg_end single cycle", msg_end, 0);
    endtask

    task automatic t_ignore_done();
        // still waiting for acknowledge after t_short_frame
        push_bytes(3);
        drive(1'b1, 1'b1, 8'h11, 1'b0);
        chk("R8", "len held", frame_len, 5);
        chk("R8", "fill held", fifo_fill, 6);
        chk("R8", "status held", frame_stat, 8'hA5);
        chk("R8", "no msg_end", msg_end, 0);
        drive(1'b0, 1'b0, 8'h00, 1'b1);
        chk("R2", "len kept after ack", frame_len, 5);
        drive(1'b0, 1'b0, 8'h00, 1'b1);
        chk("R8", "extra ack no effect", frame_len, 5);
    endtask

    task automatic t_stray_eof();
        drive(1'b0, 1'b1, 8'h22, 1'b0);
        chk("R9", "no msg_end", msg_end, 0);
        chk("R9", "status unchanged", frame_stat, 8'hA5);
        drive(1'b1, 1'b0, 8'h00, 1'b0);
        chk("R9", "frame still starts at 1", frame_len, 1);
        chk("R2", "fill restarts", fifo_fill, 1);
        drive(1'b0, 1'b1, 8'h33, 1'b0);
        chk("R6", "one-byte frame end", msg_end, 1);
        chk("R6", "fill 1+status", fifo_fill, 2);
        drive(1'b0, 1'b0, 8'h00, 1'b1);
    endtask

    task automatic t_long_frame();
        chunk_seen = 0;
        push_bytes(31);
        chk("R5", "no chunk before 32", chunk_seen, 0);
        drive(1'b1, 1'b0, 8'h00, 1'b0);
        chk("R5", "chunk at byte 32", chunk_rdy, 1);
        chk("R5", "fill wraps", fifo_fill, 0);
        idle_cycle();
        chk("R5", "chunk single cycle", chunk_rdy, 0);
        chunk_seen = 0;
        push_bytes(38);
        chk("R5", "one more chunk by 70", chunk_seen, 1);
        chk("R2", "len 70", frame_len, 70);
        chk("R4", "fill 70 mod 32", fifo_fill, 6);
        drive(1'b0, 1'b1, 8'h5C, 1'b0);
        chk("R6", "fill 6+status", fifo_fill, 7);
        chk("R6", "status", frame_stat, 8'h5C);
        drive(1'b0, 1'b0, 8'h00, 1'b1);
    endtask

    task automatic t_exact_chunk_with_eof();
        push_bytes(31);
        drive(1'b1, 1'b1, 8'h77, 1'b0);
        chk("R7", "last byte counted", frame_len, 32);
        chk("R7", "msg_end", msg_end, 1);
        chk("R5", "chunk on byte 32", chunk_rdy, 1);
        chk("R7", "fill status only", fifo_fill, 1);
        drive(1'b0, 1'b0, 8'h00, 1'b1);
        push_bytes(2);
        drive(1'b1, 1'b1, 8'h78, 1'b0);
        chk("R7", "3-byte frame len", frame_len, 3);
        chk("R7", "3-byte fill", fifo_fill, 4);
        drive(1'b0, 1'b0, 8'h00, 1'b1);
    endtask

    task automatic t_overflow();
        push_bytes(4095);
        chk("R3", "len 4095", frame_len, 4095);
        chk("R3", "no ovf at 4095", len_ovf, 0);
        push_bytes(1);
        chk("R3", "ovf set", len_ovf, 1);
        chk("R3", "len saturates", frame_len, 4095);
        chk("R4", "fill 4096 mod 32", fifo_fill, 0);
        push_bytes(4);
        chk("R3", "len still 4095", frame_len, 4095);
        chk("R4", "fill 4100 mod 32", fifo_fill, 4);
        drive(1'b0, 1'b1, 8'h99, 1'b0);
        chk("R3", "ovf held at end", len_ovf, 1);
        chk("R6", "fill 4+status", fifo_fill, 5);
        drive(1'b0, 1'b0, 8'h00, 1'b1);
        drive(1'b1, 1'b0, 8'h00, 1'b0);
        chk("R3", "ovf cleared by new frame", len_ovf, 0);
        chk("R3", "len reload", frame_len, 1);
    endtask

    task automatic t_mid_reset();
        push_bytes(3);
        do_reset();
        chk("R1", "len after reset", frame_len, 0);
        chk("R1", "fill after reset", fifo_fill, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_short_frame();
                t_ignore_done();
                t_stray_eof();
                t_long_frame();
                t_exact_chunk_with_eof();
                t_overflow();
                t_mid_reset();
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule